// File: doc/BRIEF.md
# MDIO management controller

This block is a register-programmed master for the two-wire PHY management bus. Software sets a clock divisor, a PHY address, a register address and, for writes, sixteen bits of data, then issues a command. The block generates the management clock, shifts the complete frame out on the data line, releases the line when the PHY is to answer, and captures the sixteen returned bits into a read-data register. Status bits report when a frame is in progress, whether the link is down, and whether the read data is not yet valid.

Besides single reads and writes, a scan command makes the block poll PHY register 1 again and again. Each completed poll updates a link-fail flag from the link bit the PHY returns. The scan continues until software clears the command. A 32-cycle preamble of ones precedes each frame unless software suppresses it. The host side is a flat 32-bit register port with a word select, a write strobe and a combinational read-back. The pad tristate is left to the chip level, which uses the separate output, enable and input pins.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset every register reads zero, MDC is low and the master does not drive MDIO (output enable low).
- R2: The mode register (select 0) keeps the divisor in bits 7:0 with bit 0 always read as 0. One MDC period lasts the divisor value in clock cycles, and a stored value of 0 gives a period of 2 cycles.
- R3: Every frame begins with 32 MDC cycles of ones on MDIO. When mode bit 8 is set, the frame begins directly with the start bits.
- R4: Command bit 2 sends a write frame. The frame is start 01, opcode 01, the PHY address (address register bits 4:0), the register address (address register bits 12:8), turnaround 10, and then the 16 write-data bits MSB first. The master drives every bit, and MDIO changes only while MDC is low.
- R5: Command bit 1 sends a read frame with opcode 10. The master releases MDIO from the turnaround onward, samples the 16 data bits MSB first on rising MDC, and places them in read-data bits 15:0 (select 4) when the frame ends.
- R6: Status register (select 5) bit 1 is busy. It rises in the cycle after a command write that has any of bits 2:0 set, and it falls when the frame's last bit ends. While busy is low, MDC stays low and MDIO stays released.
- R7: A command written while busy is high does not start another frame.
- R8: When several command bits are set together, write takes priority over read, and read takes priority over scan.
- R9: Command bit 0 repeats read frames of register 1 at the programmed PHY address and ignores the register field. After each poll, status bit 0 (link fail) becomes the inverse of bit 2 of the returned value, and the returned value is latched as read data.
- R10: Status bit 2 (invalid) is set when a scan starts and clears when the first scan frame completes.
- R11: Writing zero to the command register (select 1) during a scan lets the current frame finish, after which busy falls and no further frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 3 | Register word select: 0 mode, 1 command, 2 address, 3 write data, 4 read data, 5 status |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read-back of the selected register |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data the master drives onto MDIO |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO line value as sampled from the pad |

## Verification
A wrong bit position or opcode in the frame builder shows up at the PHY model after about fourteen MDC cycles, as a mismatched address or operation, or as a write landing in the wrong register. A position counter that is off by one shifts the returned data by one bit, or leaves the turnaround driven. Either fault appears in the read-data register as soon as busy drops. A fault in divisor handling shows in the first few MDC periods. A scan loop that fails to stop, or a link flag sampled from the wrong bit, shows in the status word one poll later, which is within a couple of hundred clock cycles at small divisors.

// File: rtl/mdio_mgmt.sv
module mdio_mgmt #(
  parameter int DIV_W    = 8,
  parameter int LINK_BIT = 2,
  parameter logic [4:0] SCAN_REG = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_sel,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);

  localparam logic [2:0] SEL_MODE = 3'd0;
  localparam logic [2:0] SEL_CMD  = 3'd1;
  localparam logic [2:0] SEL_ADDR = 3'd2;
  localparam logic [2:0] SEL_WDAT = 3'd3;
  localparam logic [2:0] SEL_RDAT = 3'd4;
  localparam logic [2:0] SEL_STAT = 3'd5;
  localparam int NOPRE_BIT = DIV_W;
  localparam logic [5:0] LAST_POS = 6'd63;

  typedef enum logic [1:0] {OP_WR, OP_RD, OP_SCAN} op_e;

  logic [DIV_W-1:0] div_q, div_eff, half, hcnt_q;
  logic             nopre_q;
  logic [2:0]       cmd_q;
  logic [4:0]       phy_q, rad_q;
  logic [15:0]      wdat_q, rdat_q, shift_q;
  logic             link_fail_q, invalid_q, busy_q;
  op_e              op_q, new_op;
  logic [31:0]      frame_q, new_frame, scan_frame;
  logic [5:0]       pos_q, start_pos;
  logic             tick, reading, start_req;
  logic             unused_hi;

  function automatic logic [31:0] make_frame(input logic wr, input logic [4:0] pa,
                                             input logic [4:0] ra, input logic [15:0] d);
    make_frame = wr ? {2'b01, 2'b01, pa, ra, 2'b10, d}
                    : {2'b01, 2'b10, pa, ra, 2'b11, 16'hFFFF};
  endfunction

  // returns {oe, out} for bit position p of a frame
  function automatic logic [1:0] drive_at(input logic [5:0] p, input logic [31:0] f,
                                          input logic rd);
    logic [4:0] k;
    k = p[4:0];
    if (!p[5]) return 2'b11;
    if (rd && k >= 5'd14) return 2'b01;
    return {1'b1, f[5'd31 - k]};
  endfunction

  assign unused_hi  = ^reg_wdata[31:16];
  assign div_eff    = (div_q == '0) ? DIV_W'(2) : div_q;
  assign half       = div_eff >> 1;
  assign tick       = busy_q && (hcnt_q == half - 1'b1);
  assign reading    = (op_q != OP_WR);
  assign start_pos  = nopre_q ? 6'd32 : 6'd0;
  assign start_req  = reg_we && (reg_sel == SEL_CMD) && !busy_q && (|reg_wdata[2:0]);
  assign new_op     = reg_wdata[2] ? OP_WR : (reg_wdata[1] ? OP_RD : OP_SCAN);
  assign scan_frame = make_frame(1'b0, phy_q, SCAN_REG, 16'h0);
  assign new_frame  = (new_op == OP_SCAN) ? scan_frame
                                          : make_frame(new_op == OP_WR, phy_q, rad_q, wdat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      nopre_q <= 1'b0;
      cmd_q   <= '0;
      phy_q   <= '0;
      rad_q   <= '0;
      wdat_q  <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_MODE: begin
          div_q   <= {reg_wdata[DIV_W-1:1], 1'b0};
          nopre_q <= reg_wdata[NOPRE_BIT];
        end
        SEL_CMD:  cmd_q  <= reg_wdata[2:0];
        SEL_ADDR: begin
          phy_q <= reg_wdata[4:0];
          rad_q <= reg_wdata[12:8];
        end
        SEL_WDAT: wdat_q <= reg_wdata[15:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      op_q        <= OP_WR;
      frame_q     <= '0;
      pos_q       <= '0;
      hcnt_q      <= '0;
      mdc         <= 1'b0;
      mdio_out    <= 1'b1;
      mdio_oe     <= 1'b0;
      shift_q     <= '0;
      rdat_q      <= '0;
      link_fail_q <= 1'b0;
      invalid_q   <= 1'b0;
    end else if (start_req) begin
      busy_q              <= 1'b1;
      op_q                <= new_op;
      frame_q             <= new_frame;
      pos_q               <= start_pos;
      {mdio_oe, mdio_out} <= drive_at(start_pos, new_frame, new_op != OP_WR);
      hcnt_q              <= '0;
      mdc                 <= 1'b0;
      if (new_op == OP_SCAN) invalid_q <= 1'b1;
    end else if (busy_q) begin
      if (!tick) begin
        hcnt_q <= hcnt_q + 1'b1;
      end else begin
        hcnt_q <= '0;
        if (!mdc) begin
          mdc <= 1'b1;
          if (reading && pos_q[5] && pos_q[4]) shift_q <= {shift_q[14:0], mdio_in};
        end else begin
          mdc <= 1'b0;
          if (pos_q != LAST_POS) begin
            pos_q               <= pos_q + 1'b1;
            {mdio_oe, mdio_out} <= drive_at(pos_q + 1'b1, frame_q, reading);
          end else begin
            if (reading) begin
              rdat_q    <= shift_q;
              invalid_q <= 1'b0;
            end
            if (op_q == OP_SCAN) link_fail_q <= ~shift_q[LINK_BIT];
            if (op_q == OP_SCAN && cmd_q[0]) begin
              frame_q             <= scan_frame;
              pos_q               <= start_pos;
              {mdio_oe, mdio_out} <= drive_at(start_pos, scan_frame, 1'b1);
            end else begin
              busy_q   <= 1'b0;
              mdio_oe  <= 1'b0;
              mdio_out <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_MODE: begin
        reg_rdata[DIV_W-1:0] = div_q;
        reg_rdata[NOPRE_BIT] = nopre_q;
      end
      SEL_CMD:  reg_rdata[2:0]  = cmd_q;
      SEL_ADDR: begin
        reg_rdata[4:0]  = phy_q;
        reg_rdata[12:8] = rad_q;
      end
      SEL_WDAT: reg_rdata[15:0] = wdat_q;
      SEL_RDAT: reg_rdata[15:0] = rdat_q;
      SEL_STAT: reg_rdata[2:0]  = {invalid_q, busy_q, link_fail_q};
      default: ;
    endcase
  end

  // R6
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc && !mdio_oe));

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(reg_we && reg_sel == SEL_CMD));

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $fell(mdc));

  // R4
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

  // R10
  invalid_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_q |-> (busy_q && op_q == OP_SCAN));

endmodule

// File: tb/mdio_mgmt_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int checks = 0;
  int errors = 0;

  mdio_mgmt dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  always #2.5 clk = ~clk;

  // PHY responder model
  logic [15:0] phy_mem [32];
  int          pre_cnt = 0, frames = 0, fcnt = 0, last_pre = -1, period_clk = 0;
  logic        in_frame = 1'b0, rd_frame = 1'b0, ta_oe = 1'b1;
  logic [31:0] fbits = '0;
  logic [15:0] reply = '0;
  logic [1:0]  last_op = '0;
  logic [4:0]  last_phy = '0, last_reg = '0;
  realtime     t_prev = 0;

  always @(posedge mdc) begin
    if (!in_frame) begin
      if (mdio_oe && mdio_out) pre_cnt++;
      else if (mdio_oe && !mdio_out) begin
        in_frame = 1'b1;
        fbits    = '0;
        fcnt     = 1;
        rd_frame = 1'b0;
      end
    end else begin
      fbits[31-fcnt] = mdio_oe ? mdio_out : mdio_in;
      if (fcnt == 4) t_prev = $realtime;
      if (fcnt == 5) period_clk = int'(($realtime - t_prev) / 5.0);
      if (fcnt == 13) begin
        rd_frame = (fbits[29:28] == 2'b10);
        reply    = phy_mem[fbits[22:18]];
      end
      if (fcnt == 14) ta_oe = mdio_oe;
      if (fcnt == 31) begin
        last_op  = fbits[29:28];
        last_phy = fbits[27:23];
        last_reg = fbits[22:18];
        last_pre = pre_cnt;
        pre_cnt  = 0;
        if (fbits[29:28] == 2'b01) phy_mem[fbits[22:18]] = fbits[15:0];
        frames++;
        in_frame = 1'b0;
        rd_frame = 1'b0;
      end else begin
        fcnt++;
      end
    end
  end

  always @(negedge mdc) begin
    if (in_frame && rd_frame && fcnt >= 15)
      mdio_in = (fcnt == 15) ? 1'b0 : reply[31-fcnt];
    else
      mdio_in = 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_we = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do rd(3'd5, s); while (s[1]);
  endtask

  task automatic wait_frames(input int target);
    while (frames < target) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  // {wr, nopre, div[7:0], phy[4:0], reg[4:0], pad[3:0], data[15:0]}
  localparam int NV = 7;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'd4, 5'd3,  5'd0,  4'd0, 16'hA55A},
    {1'b0, 1'b0, 8'd6, 5'd17, 5'd2,  4'd0, 16'h1234},
    {1'b1, 1'b1, 8'd5, 5'd31, 5'd31, 4'd0, 16'h8001},
    {1'b0, 1'b1, 8'd2, 5'd0,  5'd5,  4'd0, 16'hC3A5},
    {1'b0, 1'b0, 8'd1, 5'd10, 5'd30, 4'd0, 16'h0001},
    {1'b1, 1'b0, 8'd0, 5'd21, 5'd16, 4'd0, 16'h7E00},
    {1'b0, 1'b1, 8'd9, 5'd1,  5'd1,  4'd0, 16'hFFFF}
  };

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int f0;
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), r);
      check($sformatf("R1 reg %0d after reset", s), r, 32'h0);
    end
    check("R1 mdc low", {31'h0, mdc}, 32'h0);
    check("R1 mdio released", {31'h0, mdio_oe}, 32'h0);

    // R2: mode read-back drops divisor bit 0
    wr(3'd0, 32'h0000_01FF);
    rd(3'd0, r);
    check("R2 mode readback", r, 32'h0000_01FE);

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      logic        v_wr, v_np;
      logic [7:0]  v_div;
      logic [4:0]  v_phy, v_reg;
      logic [15:0] v_d;
      int          exp_per;
      v_wr  = VEC[i][39];
      v_np  = VEC[i][38];
      v_div = VEC[i][37:30];
      v_phy = VEC[i][29:25];
      v_reg = VEC[i][24:20];
      v_d   = VEC[i][15:0];
      exp_per = ((v_div & 8'hFE) == 0) ? 2 : int'(v_div & 8'hFE);
      phy_mem[v_reg] = v_wr ? 16'h0 : v_d;
      wr(3'd0, {23'h0, v_np, v_div});
      wr(3'd2, {19'h0, v_reg, 3'h0, v_phy});
      wr(3'd3, {16'h0, v_d});
      f0 = frames;
      wr(3'd1, v_wr ? 32'h4 : 32'h2);
      wait_idle();
      check($sformatf("R4 vec%0d frame count", i), frames, f0 + 1);
      check($sformatf("R4 vec%0d opcode", i), {30'h0, last_op}, v_wr ? 32'h1 : 32'h2);
      check($sformatf("R4 vec%0d phy addr", i), {27'h0, last_phy}, {27'h0, v_phy});
      check($sformatf("R4 vec%0d reg addr", i), {27'h0, last_reg}, {27'h0, v_reg});
      check($sformatf("R3 vec%0d preamble", i), last_pre, v_np ? 0 : 32);
      check($sformatf("R2 vec%0d mdc period", i), period_clk, exp_per);
      if (v_wr) begin
        check($sformatf("R4 vec%0d phy got data", i), {16'h0, phy_mem[v_reg]}, {16'h0, v_d});
      end else begin
        rd(3'd4, r);
        check($sformatf("R5 vec%0d read data", i), r, {16'h0, v_d});
        check($sformatf("R5 vec%0d turnaround released", i), {31'h0, ta_oe}, 32'h0);
      end
      wr(3'd1, 32'h0);
    end

    // R6: busy rises one cycle after the command write
    wr(3'd0, 32'h4);
    wr(3'd2, 32'h0000_0203);
    rd(3'd5, r);
    check("R6 busy low before command", r, 32'h0);
    @(negedge clk);
    reg_sel = 3'd1; reg_wdata = 32'h2; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 3'd5;
    #1 check("R6 busy high next cycle", {31'h0, reg_rdata[1]}, 32'h1);
    // R7: a command while busy is ignored
    f0 = frames;
    wr(3'd1, 32'h4);
    wait_idle();
    repeat (100) @(negedge clk);
    check("R7 single frame", frames, f0 + 1);
    check("R7 frame stays a read", {30'h0, last_op}, 32'h2);
    rd(3'd5, r);
    check("R6 busy low after frame", r, 32'h0);
    check("R6 mdc low when idle", {31'h0, mdc}, 32'h0);
    wr(3'd1, 32'h0);

    // R8: write wins over read and scan
    wr(3'd2, 32'h0000_0604);
    wr(3'd3, 32'h0000_BEEF);
    f0 = frames;
    wr(3'd1, 32'h7);
    wait_idle();
    check("R8 write has priority", {30'h0, last_op}, 32'h1);
    check("R8 write data landed", {16'h0, phy_mem[6]}, 32'h0000_BEEF);
    wr(3'd1, 32'h0);

    // R9 R10 R11: scan
    phy_mem[1] = 16'h0004;
    wr(3'd2, 32'h0000_0709);
    f0 = frames;
    wr(3'd1, 32'h1);
    rd(3'd5, r);
    check("R10 invalid and busy at scan start", r, 32'h6);
    wait_frames(f0 + 1);
    rd(3'd5, r);
    check("R10 invalid clears after first poll", r, 32'h2);
    check("R9 scan reads register 1", {27'h0, last_reg}, 32'h1);
    check("R9 scan phy address", {27'h0, last_phy}, 32'h9);
    check("R9 scan opcode read", {30'h0, last_op}, 32'h2);
    rd(3'd4, r);
    check("R9 scan latches data", r, 32'h0000_0004);
    phy_mem[1] = 16'h0000;
    wait_frames(frames + 2);
    rd(3'd5, r);
    check("R9 link fail follows PHY", r, 32'h3);
    wr(3'd1, 32'h0);
    wait_idle();
    f0 = frames;
    repeat (200) @(negedge clk);
    check("R11 scan stopped", frames, f0);
    rd(3'd5, r);
    check("R11 status after stop", r, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule